// File: doc/BRIEF.md
# Comparator Interrupt Status Register

This block is an 8-bit control and status register that sits beside an analog comparator. It takes the comparator's digital result, which is asynchronous to the core clock, and passes it through a synchroniser. Software reads the synchronised value back as a status bit. An event detector watches the synchronised level for a rising edge, a falling edge or any change, as software selects. When the chosen event occurs, the block sets a sticky flag. An interrupt request goes out when that flag, a local enable and the processor's global interrupt enable are all high.

The flag is cleared in two ways. An acknowledge pulse from the interrupt controller clears it when the vector is taken, and software can clear it by writing a one to it. A disable bit stops the comparator path: while it is set, the synchronised level reads 0 and no events are detected. Reads are combinational from `rd_data`. A write takes effect on the clock edge on which `wr_en` is high.

Top module: `cmp_irq_csr`

## Requirements
- R1: Bit 5 of `rd_data` shows the comparator level. It is 1 when `cmp_raw` is high. The new level appears two clock edges after `cmp_raw` changes.
- R2: Bits 6 and 2 of `rd_data` always read 0, whatever value is written to them.
- R3: After reset, bit 7 (disable), bit 4 (flag), bit 3 (interrupt enable) and bits 1:0 (mode) are all 0. `irq_req` is low.
- R4: With mode 2'b11, the flag is set on a 0-to-1 change of the synchronised level and not on a 1-to-0 change. The flag becomes visible one edge after the new level appears in bit 5.
- R5: With mode 2'b10, the flag is set on a 1-to-0 change and not on a 0-to-1 change.
- R6: With mode 2'b00, the flag is set on a change in either direction.
- R7: With mode 2'b01, no change of the comparator level sets the flag.
- R8: `irq_req` is high exactly when the flag (bit 4), the interrupt enable (bit 3) and `gie` are all 1.
- R9: A one-cycle pulse on `irq_ack` clears the flag at the next edge.
- R10: A write with bit 4 set clears the flag. A write with bit 4 clear leaves the flag unchanged.
- R11: If an event and a clear (acknowledge or write-one) happen in the same cycle, the flag ends up set.
- R12: While bit 7 is 1, bit 5 reads 0 from the second edge after the disable is written, and comparator changes do not set the flag.
- R13: Bits 7, 3, 1 and 0 read back the values last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator result |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Interrupt vector acknowledge pulse; clears the flag |
| gie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Interrupt request |

## Verification
The event detector is tried in every mode with both a rising and a falling comparator step. Each mode's pass and reject cases are therefore told apart: a rise-only detector is shown to ignore falls, and the reserved mode is shown to ignore both. A held-level case shows that a static input never sets the flag. Directed tests line an acknowledge up with the exact cycle of a detected event, to separate set-wins from clear-wins priority. Other directed tests toggle the comparator while it is disabled, to show that gating hides both the level and the events.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  localparam int REG_W    = 8;
  localparam int BIT_DIS  = 7;
  localparam int BIT_RSV6 = 6;
  localparam int BIT_LVL  = 5;
  localparam int BIT_FLG  = 4;
  localparam int BIT_IEN  = 3;
  localparam int BIT_RSV2 = 2;
  localparam int BIT_MDH  = 1;
  localparam int BIT_MDL  = 0;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_NONE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } evt_mode_e;

  function automatic logic edge_match(evt_mode_e m, logic prev, logic cur);
    logic up, dn;
    up = cur & ~prev;
    dn = prev & ~cur;
    case (m)
      MODE_ANY:  edge_match = up | dn;
      MODE_FALL: edge_match = dn;
      MODE_RISE: edge_match = up;
      default:   edge_match = 1'b0;
    endcase
  endfunction

  function automatic logic flag_next(logic cur, logic set, logic clr);
    if (set)      flag_next = 1'b1;
    else if (clr) flag_next = 1'b0;
    else          flag_next = cur;
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_off,
  input  logic din,
  output logic dout
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sh;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)        sh[i] <= 1'b0;
          else if (hold_off) sh[i] <= 1'b0;
          else               sh[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)        sh[i] <= 1'b0;
          else if (hold_off) sh[i] <= 1'b0;
          else               sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  assign dout = sh[LAST];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gate_off,
  input  evt_mode_e mode,
  input  logic      lvl,
  output logic      evt
);
  logic lvl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= 1'b0;
    else        lvl_prev <= lvl;
  end

  assign evt = ~gate_off & edge_match(mode, lvl_prev, lvl);
endmodule

// File: rtl/cmp_csr_regs.sv
module cmp_csr_regs
  import cmp_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             evt,
  input  logic             ack,
  input  logic             lvl,
  output logic             dis,
  output logic             ien,
  output logic             flag,
  output evt_mode_e        mode,
  output logic [REG_W-1:0] rd_data
);
  logic flag_clr;
  logic unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[BIT_RSV6], wr_data[BIT_LVL], wr_data[BIT_RSV2]};
  assign flag_clr = ack | (wr_en & wr_data[BIT_FLG]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis  <= 1'b0;
      ien  <= 1'b0;
      mode <= MODE_ANY;
    end else if (wr_en) begin
      dis  <= wr_data[BIT_DIS];
      ien  <= wr_data[BIT_IEN];
      mode <= evt_mode_e'(wr_data[BIT_MDH:BIT_MDL]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, evt, flag_clr);
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[BIT_DIS]         = dis;
    rd_data[BIT_LVL]         = lvl;
    rd_data[BIT_FLG]         = flag;
    rd_data[BIT_IEN]         = ien;
    rd_data[BIT_MDH:BIT_MDL] = mode;
  end
endmodule

// File: rtl/cmp_irq_csr.sv
module cmp_irq_csr
  import cmp_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_raw,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_ack,
  input  logic       gie,
  output logic       irq_req
);
  logic      lvl_sync;
  logic      evt_hit;
  logic      dis_q, ien_q, flag_q;
  evt_mode_e mode_q;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold_off(dis_q), .din(cmp_raw), .dout(lvl_sync)
  );

  cmp_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .gate_off(dis_q), .mode(mode_q),
    .lvl(lvl_sync), .evt(evt_hit)
  );

  cmp_csr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt(evt_hit), .ack(irq_ack), .lvl(lvl_sync),
    .dis(dis_q), .ien(ien_q), .flag(flag_q), .mode(mode_q), .rd_data(rd_data)
  );

  assign irq_req = flag_q & ien_q & gie;
endmodule

// File: rtl/cmp_irq_csr_chk.sv
module cmp_irq_csr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rd_data,
  input logic       irq_req,
  input logic       irq_ack,
  input logic       gie,
  input logic       evt
);
  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (rd_data[4] && rd_data[3] && gie)); // R8
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[6] == 1'b0) && (rd_data[2] == 1'b0)); // R2
  AST_DIS_LVL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] |=> (!rd_data[7] || !rd_data[5])); // R12
  AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !rd_data[4]) |=> !rd_data[4]); // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !evt) |=> !rd_data[4]); // R9
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> rd_data[4]); // R11
  AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1:0] == 2'b01) |-> !evt); // R7
endmodule

bind cmp_irq_csr cmp_irq_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .irq_req(irq_req),
  .irq_ack(irq_ack), .gie(gie), .evt(evt_hit)
);

// File: tb/cmp_irq_csr_test.sv
module cmp_irq_csr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq_ack = 1'b0;
  logic       gie = 1'b0;
  logic       irq_req;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cmp_irq_csr uut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_ack(irq_ack), .gie(gie), .irq_req(irq_req)
  );

  // {mode[1:0], start level, end level, expected flag}
  localparam logic [4:0] VEC [9] = '{
    {2'b11, 1'b0, 1'b1, 1'b1},  // R4 rise accepted
    {2'b11, 1'b1, 1'b0, 1'b0},  // R4 fall rejected
    {2'b10, 1'b1, 1'b0, 1'b1},  // R5 fall accepted
    {2'b10, 1'b0, 1'b1, 1'b0},  // R5 rise rejected
    {2'b00, 1'b0, 1'b1, 1'b1},  // R6 rise
    {2'b00, 1'b1, 1'b0, 1'b1},  // R6 fall
    {2'b01, 1'b0, 1'b1, 1'b0},  // R7
    {2'b01, 1'b1, 1'b0, 1'b0},  // R7
    {2'b11, 1'b0, 1'b0, 1'b0}   // R4 held level
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [7:0] v);
    wr_data = v;
    wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R3 reset value", rd_data, 8'h00);
    check("R3 request low", {7'h0, irq_req}, 8'h00);

    // R1 synchroniser latency
    cmp_raw = 1'b1;
    tick(1);
    check("R1 level after one edge", {7'h0, rd_data[5]}, 8'h00);
    tick(1);
    check("R1 level after two edges", {7'h0, rd_data[5]}, 8'h01);
    cmp_raw = 1'b0;
    tick(4);

    // Table walk: modes R4 R5 R6 R7
    for (int i = 0; i < 9; i++) begin
      cmp_raw = VEC[i][2];
      tick(4);
      reg_write({6'b000100, VEC[i][4:3]});
      tick(2);
      cmp_raw = VEC[i][1];
      tick(3);
      check($sformatf("R4-table vector %0d mode %b", i, VEC[i][4:3]),
            {7'h0, rd_data[4]}, {7'h0, VEC[i][0]});
    end
    cmp_raw = 1'b0;
    tick(4);

    // R2 and R13 readback
    reg_write(8'h4F);
    check("R2 R13 readback with reserved written", rd_data, 8'h0B);
    reg_write(8'h06);
    check("R2 R13 second pattern", rd_data, 8'h02);

    // R8 gating, flag set in rise mode with enable
    reg_write(8'h1B);
    cmp_raw = 1'b1;
    tick(3);
    check("R8 flag set", {7'h0, rd_data[4]}, 8'h01);
    gie = 1'b0;
    tick(1);
    check("R8 gie low blocks", {7'h0, irq_req}, 8'h00);
    gie = 1'b1;
    tick(1);
    check("R8 all high requests", {7'h0, irq_req}, 8'h01);
    reg_write(8'h03);
    check("R8 enable low blocks", {7'h0, irq_req}, 8'h00);
    check("R10 write zero keeps flag", {7'h0, rd_data[4]}, 8'h01);
    reg_write(8'h1B);
    check("R10 write one clears flag", {7'h0, rd_data[4]}, 8'h00);

    // R9 acknowledge
    cmp_raw = 1'b0;
    tick(4);
    cmp_raw = 1'b1;
    tick(3);
    check("R9 flag before ack", {7'h0, rd_data[4]}, 8'h01);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    check("R9 ack clears", {7'h0, rd_data[4]}, 8'h00);

    // R11 event in same cycle as ack, toggle mode, flag already set
    reg_write(8'h08);
    cmp_raw = 1'b0;
    tick(3);
    check("R11 flag set before collision", {7'h0, rd_data[4]}, 8'h01);
    cmp_raw = 1'b1;
    tick(2);
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
    check("R11 event beats ack", {7'h0, rd_data[4]}, 8'h01);

    // R12 disable
    reg_write(8'h90);
    tick(1);
    check("R12 level hidden and flag clear", rd_data, 8'h80);
    cmp_raw = 1'b0;
    tick(4);
    cmp_raw = 1'b1;
    tick(4);
    check("R12 no event while disabled", rd_data, 8'h80);
    cmp_raw = 1'b0;
    tick(4);
    reg_write(8'h00);
    tick(3);
    check("R12 re-enabled at low level", rd_data, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule